// File: doc/BRIEF.md
# SDRAM Read Burst Responder

This block models the read side of a four-bank synchronous DRAM as the memory chip sees it. It receives commands on a clocked three-bit command bus and acts on five of them: mode programming, row activation, read, burst stop and precharge. It keeps one open row per bank and enforces the minimum activate-to-read spacing. After the programmed latency it returns a burst of data words. It also drives an output-enable line that stands in for the data bus leaving and entering high impedance.

Stored data is not kept in a memory. Each word is computed from the bank, the open row and the column, so a controller under test can predict every word it should receive. A controller bench or an integration test places the block where a real SDRAM device would sit. The bench then checks that the controller samples data in the right cycle and handles burst ends correctly.

The burst sequencer has five states. IDLE waits for a read. WAIT covers the latency cycles before the output enable turns on. LEAD is the single enabled cycle before the first word. DATA drives words. DRAIN drives the words still due after a full-page stop. The transitions are named as follows:
- accept: IDLE to WAIT, on a legal read.
- reject: IDLE to IDLE, on an illegal read.
- arm: WAIT to LEAD, when the latency count expires.
- launch: LEAD to DATA.
- finish: DATA to IDLE, after the last word of a fixed burst.
- halt: DATA to DRAIN, on a stop or precharge during a full-page burst.
- flush: DRAIN to IDLE.

Top module: `sdram_rd_model`

## Requirements
- R1: The command encoding on `cmd` is 0 = no operation, 1 = mode set, 2 = activate, 3 = read, 4 = burst stop, 5 = precharge; codes 6 and 7 act as no operation. A mode set takes the burst length from `addr[2:0]` (000 = 1, 001 = 2, 010 = 4, 011 = 8, 111 = full page) and the latency from `addr[6:4]` (010 = 2, 011 = 3). If either field holds any other code, `mode_err` goes high and both settings keep their previous values. A later legal mode set clears `mode_err`.
- R2: Activate opens the bank named by `bank_sel` and captures the 12-bit row from `addr`. Every data word of a burst equals {bank[1:0], row[5:0], column[7:0]}, using the bank and row open at the time of the read.
- R3: With TRCD the activate-to-read spacing, a read sampled TRCD or more clock edges after its bank's activate is accepted. A read sampled earlier is rejected.
- R4: A read to a bank that has never been activated, or that has been precharged since its last activate, is rejected. A rejected read raises `proto_err` and produces no output enable and no data.
- R5: `proto_err` stays high until reset.
- R6: For a read accepted at clock edge k with latency CL, `dq_oe` is high from edge k+CL-1. This is one cycle before the first word.
- R7: The first word is driven after edge k+CL, and one word follows on each clock. The column starts at `addr[7:0]` of the read and increments within an aligned block of the burst length, wrapping inside that block.
- R8: For burst lengths 1, 2, 4 and 8, `dq_oe` falls on the clock after the last word. `dq_out` is zero whenever `dq_oe` is low.
- R9: A full-page burst wraps across all 256 columns until a burst stop or precharge is sampled at edge s. Words continue for CL-1 more cycles after edge s, and `dq_oe` is low from edge s+CL-1.
- R10: A read sampled while a burst is in progress is ignored. It raises no error and leaves the running burst unchanged.
- R11: After reset, `dq_oe`, `dq_out`, `proto_err` and `mode_err` are zero, all banks are closed, and the mode is burst length 4 with latency 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all commands are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 3 | Command code |
| bank_sel | input | 2 | Bank for activate, read and precharge |
| addr | input | 12 | Row on activate, column in bits [7:0] on read, mode fields on mode set |
| dq_out | output | 16 | Read data word |
| dq_oe | output | 1 | Data output enable |
| proto_err | output | 1 | Sticky flag for a rejected read |
| mode_err | output | 1 | Last mode set carried an illegal code |

## Verification
The bench sweeps every fixed burst length against both latencies. It uses start columns at and near the end of each aligned block, so a design that wrapped across the block boundary, or that started or ended the output enable one cycle off, would be seen in the first or last enabled cycle.

Full-page bursts run past column 255 and are ended by a stop and by a precharge under each latency. A drain that was one cycle too short or too long would show up as a wrong enable edge.

The activate-to-read spacing is probed one cycle early and exactly on time. A read injected into a running burst would corrupt the data if accepted. Illegal mode codes must leave the old burst length and latency in force, which the following read exposes.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;
    parameter int COL_W     = 8;
    parameter int ROW_W     = 12;
    parameter int BANKS     = 4;
    parameter int ROW_TAG_W = 6;
    localparam int BANK_W   = $clog2(BANKS);
    localparam int DATA_W   = BANK_W + ROW_TAG_W + COL_W;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_MODE = 3'd1,
        CMD_ACT  = 3'd2,
        CMD_READ = 3'd3,
        CMD_STOP = 3'd4,
        CMD_PRE  = 3'd5
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_LEAD,
        ST_DATA,
        ST_DRAIN
    } rd_state_e;

    function automatic logic [DATA_W-1:0] fill_word(
        input logic [BANK_W-1:0] b,
        input logic [ROW_W-1:0]  r,
        input logic [COL_W-1:0]  c
    );
        return {b, r[ROW_TAG_W-1:0], c};
    endfunction
endpackage

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg
    import sdram_rd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_we,
    input  logic [6:0]       mode_bits,
    output logic [COL_W-1:0] burst_mask,
    output logic             full_page,
    output logic             cl3,
    output logic             mode_err
);
    logic [COL_W-1:0] mask_d;
    logic             full_d;
    logic             cl3_d;
    logic             bl_ok;
    logic             cl_ok;

    always_comb begin
        bl_ok  = 1'b1;
        full_d = 1'b0;
        mask_d = '0;
        case (mode_bits[2:0])
            3'b000:  mask_d = COL_W'(0);
            3'b001:  mask_d = COL_W'(1);
            3'b010:  mask_d = COL_W'(3);
            3'b011:  mask_d = COL_W'(7);
            3'b111: begin
                mask_d = '1;
                full_d = 1'b1;
            end
            default: bl_ok = 1'b0;
        endcase
        cl_ok = 1'b1;
        cl3_d = 1'b0;
        case (mode_bits[6:4])
            3'b010:  cl3_d = 1'b0;
            3'b011:  cl3_d = 1'b1;
            default: cl_ok = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_mask <= COL_W'(3);
            full_page  <= 1'b0;
            cl3        <= 1'b0;
            mode_err   <= 1'b0;
        end else if (mode_we) begin
            if (bl_ok && cl_ok) begin
                burst_mask <= mask_d;
                full_page  <= full_d;
                cl3        <= cl3_d;
                mode_err   <= 1'b0;
            end else begin
                mode_err   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
    import sdram_rd_pkg::*;
#(
    parameter int TRCD = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        act_en,
    input  logic                        pre_en,
    input  logic [BANK_W-1:0]           bank,
    input  logic [ROW_W-1:0]            row_in,
    output logic [BANKS-1:0]            open_vec,
    output logic [BANKS-1:0]            ready_vec,
    output logic [BANKS-1:0][ROW_W-1:0] row_vec
);
    localparam int CNT_W = (TRCD < 2) ? 1 : $clog2(TRCD);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(TRCD - 1);

    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        logic             open_q;
        logic [CNT_W-1:0] wait_q;
        logic [ROW_W-1:0] row_q;
        logic             hit;

        assign hit = (bank == BANK_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q <= 1'b0;
                wait_q <= '0;
                row_q  <= '0;
            end else if (act_en && hit) begin
                open_q <= 1'b1;
                wait_q <= LOAD;
                row_q  <= row_in;
            end else begin
                if (pre_en && hit)
                    open_q <= 1'b0;
                if (wait_q != '0)
                    wait_q <= wait_q - 1'b1;
            end
        end

        assign open_vec[g]  = open_q;
        assign ready_vec[g] = (wait_q == '0);
        assign row_vec[g]   = row_q;
    end
endmodule

// File: rtl/sdram_burst_fsm.sv
module sdram_burst_fsm
    import sdram_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic [COL_W-1:0]  col_in,
    input  logic              bank_ok,
    input  logic [ROW_W-1:0]  row_sel,
    input  logic [COL_W-1:0]  burst_mask,
    input  logic              full_page,
    input  logic              cl3,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              proto_err,
    output logic              data_phase
);
    rd_state_e         st_q, st_d;
    logic              cnt_q, cnt_d;
    logic [COL_W-1:0]  rem_q, rem_d;
    logic [COL_W-1:0]  col_q, col_d;
    logic [COL_W-1:0]  mask_q, mask_d;
    logic              full_q, full_d;
    logic              cl3_q, cl3_d;
    logic [BANK_W-1:0] bank_q, bank_d;
    logic [ROW_W-1:0]  row_q, row_d;
    logic              err_q, err_d;
    logic              rd_cmd, stop_cmd;
    logic [COL_W-1:0]  col_step;

    assign rd_cmd   = (cmd == CMD_READ);
    assign stop_cmd = (cmd == CMD_STOP) || (cmd == CMD_PRE);
    assign col_step = (col_q & ~mask_q) | ((col_q + 1'b1) & mask_q);

    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        rem_d  = rem_q;
        col_d  = col_q;
        mask_d = mask_q;
        full_d = full_q;
        cl3_d  = cl3_q;
        bank_d = bank_q;
        row_d  = row_q;
        err_d  = err_q;
        unique case (st_q)
            ST_IDLE: begin
                if (rd_cmd) begin
                    if (bank_ok) begin
                        st_d   = ST_WAIT;
                        cnt_d  = cl3;
                        col_d  = col_in;
                        mask_d = burst_mask;
                        full_d = full_page;
                        cl3_d  = cl3;
                        bank_d = bank_sel;
                        row_d  = row_sel;
                    end else begin
                        err_d  = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (!cnt_q) st_d = ST_LEAD;
                else        cnt_d = 1'b0;
            end
            ST_LEAD: begin
                st_d  = ST_DATA;
                rem_d = mask_q;
            end
            ST_DATA: begin
                col_d = col_step;
                if (full_q) begin
                    if (stop_cmd) begin
                        st_d  = ST_DRAIN;
                        cnt_d = cl3_q;
                    end
                end else if (rem_q == '0) begin
                    st_d = ST_IDLE;
                end else begin
                    rem_d = rem_q - 1'b1;
                end
            end
            ST_DRAIN: begin
                col_d = col_step;
                if (!cnt_q) st_d = ST_IDLE;
                else        cnt_d = 1'b0;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= 1'b0;
            rem_q  <= '0;
            col_q  <= '0;
            mask_q <= '0;
            full_q <= 1'b0;
            cl3_q  <= 1'b0;
            bank_q <= '0;
            row_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            rem_q  <= rem_d;
            col_q  <= col_d;
            mask_q <= mask_d;
            full_q <= full_d;
            cl3_q  <= cl3_d;
            bank_q <= bank_d;
            row_q  <= row_d;
            err_q  <= err_d;
        end
    end

    always_comb begin
        data_phase = (st_q == ST_DATA) || (st_q == ST_DRAIN);
        dq_oe      = data_phase || (st_q == ST_LEAD);
        dq_out     = data_phase ? fill_word(bank_q, row_q, col_q) : '0;
        proto_err  = err_q;
    end
endmodule

// File: rtl/sdram_rd_model.sv
module sdram_rd_model
    import sdram_rd_pkg::*;
#(
    parameter int TRCD = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic [ROW_W-1:0]  addr,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              proto_err,
    output logic              mode_err
);
    logic [COL_W-1:0]            burst_mask;
    logic                        full_page;
    logic                        cl3;
    logic [BANKS-1:0]            open_vec;
    logic [BANKS-1:0]            ready_vec;
    logic [BANKS-1:0][ROW_W-1:0] row_vec;
    logic                        bank_ok;
    logic                        data_phase;

    sdram_mode_reg u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_we    (cmd == CMD_MODE),
        .mode_bits  (addr[6:0]),
        .burst_mask (burst_mask),
        .full_page  (full_page),
        .cl3        (cl3),
        .mode_err   (mode_err)
    );

    sdram_bank_tracker #(.TRCD(TRCD)) u_banks (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_en    (cmd == CMD_ACT),
        .pre_en    (cmd == CMD_PRE),
        .bank      (bank_sel),
        .row_in    (addr),
        .open_vec  (open_vec),
        .ready_vec (ready_vec),
        .row_vec   (row_vec)
    );

    assign bank_ok = open_vec[bank_sel] && ready_vec[bank_sel];

    sdram_burst_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd),
        .bank_sel   (bank_sel),
        .col_in     (addr[COL_W-1:0]),
        .bank_ok    (bank_ok),
        .row_sel    (row_vec[bank_sel]),
        .burst_mask (burst_mask),
        .full_page  (full_page),
        .cl3        (cl3),
        .dq_out     (dq_out),
        .dq_oe      (dq_oe),
        .proto_err  (proto_err),
        .data_phase (data_phase)
    );
endmodule

// File: rtl/sdram_rd_checker.sv
module sdram_rd_checker
    import sdram_rd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              dq_oe,
    input logic              proto_err,
    input logic              data_phase,
    input logic [DATA_W-1:0] dq_out
);
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err); // R5
    AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe |-> (dq_out == '0)); // R8
    AST_LEAD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe) |-> !data_phase); // R6
    AST_LEAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe) |=> data_phase); // R6
    AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(proto_err) |-> !dq_oe); // R4
    AST_TAG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_phase && $past(data_phase)) |-> (dq_out[DATA_W-1:COL_W] == $past(dq_out[DATA_W-1:COL_W]))); // R2
endmodule

bind sdram_rd_model sdram_rd_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dq_oe      (dq_oe),
    .proto_err  (proto_err),
    .data_phase (data_phase),
    .dq_out     (dq_out)
);

// File: tb/sdram_rd_model_tb_top.sv
module sdram_rd_model_tb_top;
    import sdram_rd_pkg::*;

    localparam int TRCD = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        cmd = 3'd0;
    logic [BANK_W-1:0] bank = '0;
    logic [ROW_W-1:0]  addr = '0;
    logic [DATA_W-1:0] dq_out;
    logic              dq_oe;
    logic              proto_err;
    logic              mode_err;

    int checks = 0;
    int fails = 0;
    bit err_expect = 1'b0;
    int rows [4];

    always #10 clk = ~clk;

    sdram_rd_model #(.TRCD(TRCD)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .bank_sel  (bank),
        .addr      (addr),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe),
        .proto_err (proto_err),
        .mode_err  (mode_err)
    );

    function automatic logic [DATA_W-1:0] exp_word(int b, int r, int c);
        logic [BANK_W-1:0] bb = BANK_W'(b);
        logic [ROW_W-1:0]  rr = ROW_W'(r);
        logic [COL_W-1:0]  cc = COL_W'(c);
        return {bb, rr[ROW_TAG_W-1:0], cc};
    endfunction

    task automatic chk(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(logic [2:0] c, int b, int a);
        cmd  = c;
        bank = BANK_W'(b);
        addr = ROW_W'(a);
        @(posedge clk);
        @(negedge clk);
        cmd  = CMD_NOP;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cyc(CMD_NOP, 0, 0);
        cyc(CMD_NOP, 0, 0);
        rst_n = 1'b1;
        err_expect = 1'b0;
    endtask

    task automatic set_mode(logic [2:0] blc, logic [2:0] clc);
        cyc(CMD_MODE, 0, {5'b0, clc, 1'b0, blc});
    endtask

    task automatic open_bank(int b, int r);
        cyc(CMD_ACT, b, r);
        for (int i = 0; i < TRCD - 1; i++) cyc(CMD_NOP, 0, 0);
    endtask

    task automatic run_burst(int b, int r, int start, int bl, int cl,
                             int inj_j, logic [2:0] inj_c, int inj_b, int inj_a);
        int m = bl - 1;
        cyc(CMD_READ, b, start);
        for (int j = 0; j <= cl + bl + 1; j++) begin
            bit eo = (j >= cl - 1) && (j <= cl + bl - 1);
            if (j == cl - 1) chk(dq_oe == eo, "R6 oe lead", dq_oe, eo);
            else             chk(dq_oe == eo, "R8 oe window", dq_oe, eo);
            if (j >= cl && j <= cl + bl - 1) begin
                int c = (start & ~m) | ((start + j - cl) & m);
                chk(dq_out == exp_word(b, r, c), "R7 data word", dq_out, exp_word(b, r, c));
            end else begin
                chk(dq_out == '0, "R8 idle data", dq_out, 0);
            end
            if (j == inj_j) cyc(inj_c, inj_b, inj_a);
            else            cyc(CMD_NOP, 0, 0);
        end
        chk(proto_err == err_expect, "R10 error flag after burst", proto_err, err_expect);
    endtask

    task automatic run_full(int b, int r, int start, int cl, int j0, logic [2:0] stopc);
        int sj = j0 + 1;
        cyc(CMD_READ, b, start);
        for (int j = 0; j <= sj + cl; j++) begin
            bit eo = (j >= cl - 1) && (j <= sj + cl - 2);
            chk(dq_oe == eo, "R9 oe window", dq_oe, eo);
            if (j >= cl && j <= sj + cl - 2) begin
                int c = (start + j - cl) % 256;
                chk(dq_out == exp_word(b, r, c), "R9 page word", dq_out, exp_word(b, r, c));
            end else begin
                chk(dq_out == '0, "R8 idle data", dq_out, 0);
            end
            if (j == j0) cyc(stopc, b, 0);
            else         cyc(CMD_NOP, 0, 0);
        end
    endtask

    task automatic expect_silent(int n, string tag);
        for (int j = 0; j < n; j++) begin
            chk(dq_oe == 1'b0, tag, dq_oe, 0);
            cyc(CMD_NOP, 0, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        int starts [4] = '{0, 3, 'h7D, 'hFE};
        @(negedge clk);
        do_reset();
        // R11 reset state
        chk(dq_oe == 1'b0, "R11 oe", dq_oe, 0);
        chk(dq_out == '0, "R11 data", dq_out, 0);
        chk(proto_err == 1'b0, "R11 proto_err", proto_err, 0);
        chk(mode_err == 1'b0, "R11 mode_err", mode_err, 0);

        // R11 default mode is length 4, latency 2; R3 read exactly TRCD after activate
        open_bank(1, 'h123);
        run_burst(1, 'h123, 6, 4, 2, -1, CMD_NOP, 0, 0);
        chk(proto_err == 1'b0, "R3 on-time read accepted", proto_err, 0);

        // R2 all banks open with distinct rows
        for (int b = 0; b < 4; b++) begin
            rows[b] = 'h0A5 + b * 'h111;
            open_bank(b, rows[b]);
        end

        // R7 R8 sweep over fixed lengths and both latencies
        for (int blc = 0; blc < 4; blc++) begin
            for (int cl = 2; cl <= 3; cl++) begin
                set_mode(3'(blc), (cl == 2) ? 3'b010 : 3'b011);
                for (int s = 0; s < 4; s++) begin
                    int b = (blc + cl + s) % 4;
                    run_burst(b, rows[b], starts[s], 1 << blc, cl, -1, CMD_NOP, 0, 0);
                end
            end
        end

        // R10 read during a running burst is ignored
        set_mode(3'b011, 3'b011);
        run_burst(0, rows[0], 2, 8, 3, 4, CMD_READ, 2, 'h40);
        set_mode(3'b001, 3'b010);
        run_burst(3, rows[3], 1, 2, 2, 2, CMD_READ, 1, 'h10);

        // R9 full page with wrap, ended by stop and by precharge
        set_mode(3'b111, 3'b010);
        run_full(2, rows[2], 'hF0, 2, 270, CMD_STOP);
        set_mode(3'b111, 3'b011);
        run_full(1, rows[1], 'h10, 3, 5, CMD_STOP);
        run_full(3, rows[3], 'hFD, 3, 4, CMD_PRE);
        chk(proto_err == 1'b0, "R9 no error after page bursts", proto_err, 0);

        // R4 read to a precharged bank
        cyc(CMD_READ, 3, 0);
        chk(proto_err == 1'b1, "R4 precharged bank rejected", proto_err, 1);
        expect_silent(6, "R4 no output after reject");

        // R1 illegal mode codes keep the old settings
        do_reset();
        set_mode(3'b010, 3'b011);
        chk(mode_err == 1'b0, "R1 legal mode", mode_err, 0);
        set_mode(3'b100, 3'b010);
        chk(mode_err == 1'b1, "R1 illegal length code", mode_err, 1);
        open_bank(0, 'h2C7);
        run_burst(0, 'h2C7, 5, 4, 3, -1, CMD_NOP, 0, 0);
        set_mode(3'b001, 3'b001);
        chk(mode_err == 1'b1, "R1 illegal latency code", mode_err, 1);
        run_burst(0, 'h2C7, 'hB, 4, 3, -1, CMD_NOP, 0, 0);
        set_mode(3'b000, 3'b010);
        chk(mode_err == 1'b0, "R1 legal mode clears flag", mode_err, 0);
        run_burst(0, 'h2C7, 'h33, 1, 2, -1, CMD_NOP, 0, 0);

        // R3 read one cycle early is rejected
        do_reset();
        set_mode(3'b010, 3'b010);
        cyc(CMD_ACT, 2, 'h3C3);
        cyc(CMD_READ, 2, 0);
        chk(proto_err == 1'b1, "R3 early read rejected", proto_err, 1);
        expect_silent(5, "R3 no output after early read");

        // R5 flag stays set across a later legal burst
        err_expect = 1'b1;
        open_bank(2, 'h3C3);
        run_burst(2, 'h3C3, 9, 4, 2, -1, CMD_NOP, 0, 0);
        chk(proto_err == 1'b1, "R5 sticky flag", proto_err, 1);
        do_reset();
        chk(proto_err == 1'b0, "R5 reset clears flag", proto_err, 0);

        // R4 bank never activated
        cyc(CMD_READ, 1, 4);
        chk(proto_err == 1'b1, "R4 closed bank rejected", proto_err, 1);
        expect_silent(5, "R4 no output for closed bank");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule